// File: doc/BRIEF.md
# Page-Mode DRAM Supercell Access Controller

This block pairs a small synchronous DRAM core with the controller that drives it. The core stores a grid of 8-bit supercells, 4 rows by 4 columns by default. One word-wide row buffer sits between the grid and the data path. A requester presents a read or a write with a row and a column over a valid/ready handshake. The controller turns each request into strobes on a time-multiplexed address bus. A row strobe carries the row index and copies that row into the buffer. A column strobe carries the column index and reads or updates one supercell in the buffer.

The controller remembers which row the buffer holds. A request to that open row skips the row strobe and issues only a column strobe, in the manner of fast page mode. A request to any other row first commits the buffer back to its home row, then opens the new row. Writes only touch the buffer. The grid sees them when the row is closed. Read data comes back on a registered output with a one-cycle valid pulse. Every action happens on the rising clock edge.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, row_stb, col_stb and rd_valid are 0, rd_data is 0 and no row is open, so the first request always issues a row strobe.
- R2: A request to a row while no row is open is followed by one cycle with row_stb=1 and mux_addr equal to the row, then one cycle with col_stb=1 and mux_addr equal to the column.
- R3: A request to the open row is followed by exactly one cycle with col_stb=1 and mux_addr equal to the column, with no row strobe.
- R4: A request to a row other than the open one is followed by one write-back cycle with both strobes 0 and mux_addr 0, then the row strobe cycle, then the column strobe cycle.
- R5: A read raises rd_valid for exactly one cycle, the cycle right after its column strobe cycle, with rd_data holding the addressed supercell.
- R6: A write stores req_wdata into the addressed supercell of the row buffer, so a later read of it returns the new value, and a write never raises rd_valid.
- R7: When a row is closed, its buffer contents, writes included, are committed to the grid, so reopening that row returns them. Other rows are left unchanged.
- R8: req_ready is 0 from the cycle after a request is accepted until the cycle that follows its column strobe. A request presented while req_ready is 0 is ignored.
- R9: At most one strobe is active in any cycle, and mux_addr is 0 whenever neither strobe is active.
- R10: Reset clears every supercell of the grid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all actions on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (2) | Row index of the request |
| req_col | input | COL_W (2) | Column index of the request |
| req_wdata | input | DATA_W (8) | Write data |
| row_stb | output | 1 | Row strobe, row index on mux_addr |
| col_stb | output | 1 | Column strobe, column index on mux_addr |
| mux_addr | output | ADDR_W (2) | Time-multiplexed row/column address |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DATA_W (8) | Read data |

## Verification
The bench builds the block with its default 4 by 4 grid of 8-bit cells. At that size all sixteen supercells can be filled and read back in an order that walks across every row, so every access path is reached many times: the cold open, the open-row hit, and the close-and-reopen. Row changes that carry pending writes show whether the write-back lands on the right row and leaves the others alone. A mid-run reset checks that the grid is cleared and that the open row is forgotten.

// File: rtl/pmdram_pkg.sv
package pmdram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBACK  = 2'd1,
        ST_ROWSTB = 2'd2,
        ST_COLSTB = 2'd3
    } seq_state_e;

    // Index width for a count of n items, never less than one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmdram_array.sv
module pmdram_array #(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned COLS   = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ROW_W-1:0]             sel_row,
    input  logic                         wb_en,
    input  logic [COLS-1:0][DATA_W-1:0]  wb_data,
    output logic [COLS-1:0][DATA_W-1:0]  row_out
);

    logic [COLS-1:0][DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < int'(ROWS); r++) begin
                cells[r] <= '0;
            end
        end else if (wb_en) begin
            cells[sel_row] <= wb_data;
        end
    end

    assign row_out = cells[sel_row];

endmodule

// File: rtl/pmdram_rowbuf.sv
module pmdram_rowbuf #(
    parameter int unsigned COLS   = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned COL_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_en,
    input  logic [COLS-1:0][DATA_W-1:0]  load_data,
    input  logic                         wr_en,
    input  logic [COL_W-1:0]             col,
    input  logic [DATA_W-1:0]            wdata,
    output logic [COLS-1:0][DATA_W-1:0]  row_q,
    output logic [DATA_W-1:0]            word_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (load_en) begin
            row_q <= load_data;
        end else if (wr_en) begin
            row_q[col] <= wdata;
        end
    end

    assign word_q = row_q[col];

endmodule

// File: rtl/pmdram_seq.sv
module pmdram_seq
    import pmdram_pkg::*;
#(
    parameter int unsigned ROW_W  = 2,
    parameter int unsigned COL_W  = 2,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              row_stb,
    output logic              col_stb,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              wb_en,
    output logic              buf_load,
    output logic              buf_wr,
    output logic              rd_capture,
    output logic [ROW_W-1:0]  array_row,
    output logic [COL_W-1:0]  cur_col,
    output logic [DATA_W-1:0] cur_wdata
);

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } pend_t;

    seq_state_e       state;
    pend_t            pend;
    logic             open_vld;
    logic [ROW_W-1:0] open_row;
    logic             accept;
    logic             is_hit;

    assign accept = req_valid && (state == ST_IDLE);
    assign is_hit = open_vld && (req_row == open_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend     <= '0;
            open_vld <= 1'b0;
            open_row <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        pend <= '{wr: req_write, row: req_row,
                                  col: req_col, wdata: req_wdata};
                        if (is_hit)        state <= ST_COLSTB;
                        else if (open_vld) state <= ST_WBACK;
                        else               state <= ST_ROWSTB;
                    end
                end
                ST_WBACK:  state <= ST_ROWSTB;
                ST_ROWSTB: begin
                    state    <= ST_COLSTB;
                    open_vld <= 1'b1;
                    open_row <= pend.row;
                end
                ST_COLSTB: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        row_stb    = (state == ST_ROWSTB);
        col_stb    = (state == ST_COLSTB);
        wb_en      = (state == ST_WBACK);
        buf_load   = row_stb;
        buf_wr     = col_stb && pend.wr;
        rd_capture = col_stb && !pend.wr;
        array_row  = (state == ST_WBACK) ? open_row : pend.row;
        cur_col    = pend.col;
        cur_wdata  = pend.wdata;
        unique case (state)
            ST_ROWSTB: mux_addr = ADDR_W'(pend.row);
            ST_COLSTB: mux_addr = ADDR_W'(pend.col);
            default:   mux_addr = '0;
        endcase
    end

endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl
    import pmdram_pkg::*;
#(
    parameter int unsigned ROWS   = 4,
    parameter int unsigned COLS   = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = idx_w(ROWS),
    parameter int unsigned COL_W  = idx_w(COLS),
    parameter int unsigned ADDR_W = max2(ROW_W, COL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              row_stb,
    output logic              col_stb,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic                        wb_en;
    logic                        buf_load;
    logic                        buf_wr;
    logic                        rd_capture;
    logic [ROW_W-1:0]            array_row;
    logic [COL_W-1:0]            cur_col;
    logic [DATA_W-1:0]           cur_wdata;
    logic [COLS-1:0][DATA_W-1:0] grid_row;
    logic [COLS-1:0][DATA_W-1:0] buf_row;
    logic [DATA_W-1:0]           buf_word;

    pmdram_seq #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .row_stb   (row_stb),
        .col_stb   (col_stb),
        .mux_addr  (mux_addr),
        .wb_en     (wb_en),
        .buf_load  (buf_load),
        .buf_wr    (buf_wr),
        .rd_capture(rd_capture),
        .array_row (array_row),
        .cur_col   (cur_col),
        .cur_wdata (cur_wdata)
    );

    pmdram_array #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .DATA_W(DATA_W),
        .ROW_W (ROW_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .sel_row(array_row),
        .wb_en  (wb_en),
        .wb_data(buf_row),
        .row_out(grid_row)
    );

    pmdram_rowbuf #(
        .COLS  (COLS),
        .DATA_W(DATA_W),
        .COL_W (COL_W)
    ) u_rowbuf (
        .clk      (clk),
        .rst      (rst),
        .load_en  (buf_load),
        .load_data(grid_row),
        .wr_en    (buf_wr),
        .col      (cur_col),
        .wdata    (cur_wdata),
        .row_q    (buf_row),
        .word_q   (buf_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_capture;
            if (rd_capture) rd_data <= buf_word;
        end
    end

endmodule

// File: rtl/pmdram_chk.sv
module pmdram_chk #(
    parameter int unsigned ROW_W  = 2,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ROW_W-1:0]  req_row,
    input logic              row_stb,
    input logic              col_stb,
    input logic [ADDR_W-1:0] mux_addr,
    input logic              rd_valid
);

    // Row last opened, as seen on the strobe pins.
    logic              seen_vld;
    logic [ADDR_W-1:0] seen_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_vld <= 1'b0;
            seen_row <= '0;
        end else if (row_stb) begin
            seen_vld <= 1'b1;
            seen_row <= mux_addr;
        end
    end

    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !(row_stb && col_stb));

    p_quiet_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (!row_stb && !col_stb) |-> (mux_addr == '0));

    p_row_then_col_r2: assert property (@(posedge clk) disable iff (rst)
        row_stb |=> col_stb);

    p_hit_col_only_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && seen_vld && (ADDR_W'(req_row) == seen_row))
        |=> (col_stb && !row_stb));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_rdv_after_col_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(col_stb));

    p_rdv_single_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

bind pagemode_dram_ctrl pmdram_chk #(
    .ROW_W (ROW_W),
    .ADDR_W(ADDR_W)
) u_pmdram_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_row  (req_row),
    .row_stb  (row_stb),
    .col_stb  (col_stb),
    .mux_addr (mux_addr),
    .rd_valid (rd_valid)
);

// File: tb/test_pagemode_dram_ctrl.sv
`timescale 1ns/1ps
module test_pagemode_dram_ctrl;

    localparam int NR = 4;
    localparam int NC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [1:0] req_row = '0;
    logic [1:0] req_col = '0;
    logic [7:0] req_wdata = '0;
    logic       row_stb;
    logic       col_stb;
    logic [1:0] mux_addr;
    logic       rd_valid;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    pagemode_dram_ctrl i_pagemode_dram_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .row_stb(row_stb), .col_stb(col_stb), .mux_addr(mux_addr),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    // Behavioural reference: committed grid, buffer copy, open row.
    int  mdl_mem [NR][NC];
    int  mdl_buf [NC];
    bit  mdl_open;
    int  mdl_row;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) mdl_mem[r][c] = 0;
        for (int c = 0; c < NC; c++) mdl_buf[c] = 0;
        mdl_open = 0;
        mdl_row  = 0;
    endtask

    task automatic check_idle(input string req);
        chk(req_ready == 1'b1, "R8", "ready in idle", int'(req_ready), 1);
        chk(row_stb == 1'b0 && col_stb == 1'b0, req, "no strobe in idle",
            int'({row_stb, col_stb}), 0);
        chk(mux_addr == 2'd0, "R9", "mux_addr in idle", int'(mux_addr), 0);
    endtask

    // One request; every cycle until the design is idle again is checked.
    task automatic do_req(input bit wr, input int row, input int col,
                          input int wd, input bit junk);
        int  kind [3];
        int  n;
        bit  hit;
        int  exp_rd;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R5", "rd_valid before request", int'(rd_valid), 0);
        check_idle("R9");
        req_valid = 1'b1; req_write = wr;
        req_row = 2'(row); req_col = 2'(col); req_wdata = 8'(wd);
        hit = mdl_open && (row == mdl_row);
        if (hit) begin
            n = 1; kind[0] = 2;
        end else if (mdl_open) begin
            n = 3; kind[0] = 0; kind[1] = 1; kind[2] = 2;
            for (int c = 0; c < NC; c++) mdl_mem[mdl_row][c] = mdl_buf[c];
        end else begin
            n = 2; kind[0] = 1; kind[1] = 2;
        end
        if (!hit) begin
            for (int c = 0; c < NC; c++) mdl_buf[c] = mdl_mem[row][c];
            mdl_open = 1; mdl_row = row;
        end
        exp_rd = mdl_buf[col];
        if (wr) mdl_buf[col] = wd;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (junk) begin
                // R8: requests while busy must be ignored
                req_valid = 1'b1; req_write = 1'b1;
                req_row = 2'(row + 1 + k); req_col = 2'(col + 3);
                req_wdata = 8'hEE;
            end else begin
                req_valid = 1'b0;
            end
            chk(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
            chk(rd_valid == 1'b0, "R5", "rd_valid while busy", int'(rd_valid), 0);
            if (kind[k] == 0) begin
                chk(!row_stb && !col_stb && mux_addr == 2'd0, "R4",
                    "write-back cycle strobes/addr",
                    int'({row_stb, col_stb, mux_addr}), 0);
            end else if (kind[k] == 1) begin
                chk(row_stb && !col_stb, "R2", "row strobe cycle",
                    int'({row_stb, col_stb}), 2);
                chk(mux_addr == 2'(row), "R2", "row on mux_addr", int'(mux_addr), row);
            end else begin
                chk(col_stb && !row_stb, hit ? "R3" : "R2", "column strobe cycle",
                    int'({row_stb, col_stb}), 1);
                chk(mux_addr == 2'(col), hit ? "R3" : "R2", "column on mux_addr",
                    int'(mux_addr), col);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        check_idle("R9");
        if (wr) begin
            chk(rd_valid == 1'b0, "R6", "no rd_valid for write", int'(rd_valid), 0);
        end else begin
            chk(rd_valid == 1'b1, "R5", "rd_valid after column", int'(rd_valid), 1);
            chk(int'(rd_data) == exp_rd, "R5", "read data", int'(rd_data), exp_rd);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        mdl_reset();
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(!row_stb && !col_stb, "R1", "strobes after reset", int'({row_stb, col_stb}), 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);
        chk(rd_data == 8'd0, "R1", "rd_data after reset", int'(rd_data), 0);
        rst = 1'b0;

        // R1/R2/R10: first access opens the row, grid reads zero
        do_req(0, 0, 0, 0, 0);
        // R6/R3: write then read within the open row
        do_req(1, 0, 1, 8'hA5, 0);
        do_req(0, 0, 1, 0, 0);
        // R8: busy-time requests ignored
        do_req(1, 0, 3, 8'h3C, 1);
        do_req(0, 0, 3, 0, 1);
        // R4/R10: row change with write-back
        do_req(0, 2, 2, 0, 0);
        do_req(1, 2, 0, 8'h77, 0);
        // R7: reopen row 0, then row 2
        do_req(0, 0, 1, 0, 0);
        do_req(0, 0, 3, 0, 0);
        do_req(0, 0, 0, 0, 0);
        do_req(0, 2, 0, 0, 0);
        do_req(0, 1, 2, 0, 0);

        // R7: fill the whole grid row by row, read back column by column
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                do_req(1, r, c, r * 16 + c + 1, 0);
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++)
                do_req(0, r, c, 0, (r + c) % 2);

        // R10/R1: reset clears grid and forgets the open row
        apply_reset();
        @(negedge clk);
        chk(rd_data == 8'd0, "R1", "rd_data after second reset", int'(rd_data), 0);
        do_req(0, 3, 3, 0, 0);
        do_req(0, 3, 0, 0, 0);
        do_req(0, 1, 1, 0, 0);

        finish_run();
    end

endmodule